// File: doc/BRIEF.md
# Signed-Digit Format Converter

This block moves integers between ordinary two's complement and a radix-two signed-digit form. In that form each digit position carries a value of -1, 0 or +1 and is held as two bits, one in a positive vector and one in a negative vector. The forward direction takes a K-bit two's complement word and produces the two vectors. It needs no logic: the sign bit becomes the negative weight of the top digit, and every lower bit becomes a positive digit. The reverse direction takes any pair of vectors and returns their value, found by subtracting the negative vector from the positive one. The result is one bit wider than K, so the whole symmetric range of a K-digit signed-digit number fits.

Each direction has its own ports and its own valid/ready channel. A parameter selects one of two output styles: a single register stage that holds its result while the consumer stalls, or a direct combinational path. Signed-digit values are redundant, meaning several digit patterns stand for the same number. The reverse path gives one result for all of them, including patterns in which a digit has both of its bits set.

Top module: `bsd_conv`

## Requirements
- R1: Digit i is the bit pair (fo_pos[i], fo_neg[i]) on output, or (bd_pos[i], bd_neg[i]) on input. (1,0) means +1, (0,0) means 0 and (0,1) means -1. Digit i has weight 2^i.
- R2: In the forward result, fo_neg[K-1] equals tc_data[K-1], fo_pos[K-1] is 0, and fo_neg[K-2:0] is all zero.
- R3: In the forward result, fo_pos[K-2:0] equals tc_data[K-2:0].
- R4: No forward result has fo_pos[i] and fo_neg[i] both set at any position i.
- R5: ro_data is the (K+1)-bit two's complement value of bd_pos minus bd_neg, with both vectors read as unsigned.
- R6: Different digit patterns with the same value give the same ro_data. An input digit with both bits set counts as 0.
- R7: Values up to +(2^K-1) and down to -(2^K-1) come out exactly. ro_data never takes the value -2^K (sign bit set, all other bits clear).
- R8: With REG_OUT=1, each result appears one cycle after its input is accepted. An offered result stays unchanged while its ready is low. An input ready is high when the stage is empty or its output is being taken.
- R9: With REG_OUT=0, outputs follow inputs in the same cycle. Output valid equals input valid, and input ready equals output ready.
- R10: With REG_OUT=1, after reset both output valids are low and both input readies are high.
- R11: A forward result fed back through the reverse path returns the original K-bit value, sign-extended to K+1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_valid | input | 1 | Two's complement word offered |
| tc_ready | output | 1 | Forward path accepts the word |
| tc_data | input | K | Two's complement word to convert |
| fo_valid | output | 1 | Forward result offered |
| fo_ready | input | 1 | Consumer takes the forward result |
| fo_pos | output | K | Positive digit vector |
| fo_neg | output | K | Negative digit vector |
| bd_valid | input | 1 | Signed-digit pair offered |
| bd_ready | output | 1 | Reverse path accepts the pair |
| bd_pos | input | K | Positive digit vector in |
| bd_neg | input | K | Negative digit vector in |
| ro_valid | output | 1 | Reverse result offered |
| ro_ready | input | 1 | Consumer takes the reverse result |
| ro_data | output | K+1 | Two's complement value of the pair |

## Verification
The bench builds two instances with K=6: one with REG_OUT=1, under random backpressure, and one with REG_OUT=0 that shares the same inputs. With K=6, all 64 forward inputs and their round trips can be tested exhaustively. The reverse path gets random pairs, pairs that reach both extremes (+63 and -63), and several redundant encodings of the same value, including digits with both bits set. Running both output styles against one input stream covers the registered hold-under-stall behaviour and the combinational pass-through together.

// File: rtl/bsd_conv_pkg.sv
package bsd_conv_pkg;

    // Two-bit code of one signed digit: {plus, minus}
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_NEG  = 2'b01,
        DIG_POS  = 2'b10,
        DIG_BOTH = 2'b11
    } digit_code_t;

    // Numeric weight of a digit code; both bits set cancels to zero
    function automatic int digit_value(input digit_code_t code);
        case (code)
            DIG_POS: return 1;
            DIG_NEG: return -1;
            default: return 0;
        endcase
    endfunction

    // Digit code produced for one two's complement bit
    function automatic digit_code_t encode_bit(input logic bit_in, input logic is_sign);
        if (!bit_in)
            return DIG_ZERO;
        return is_sign ? DIG_NEG : DIG_POS;
    endfunction

endpackage

// File: rtl/bsd_conv_fwd.sv
module bsd_conv_fwd
    import bsd_conv_pkg::*;
#(
    parameter int K = 16
) (
    input  logic [K-1:0] tc_in,
    output logic [K-1:0] pos_out,
    output logic [K-1:0] neg_out
);

    localparam int SIGN_POS = K - 1;

    digit_code_t codes [K];

    for (genvar i = 0; i < K; i++) begin : g_digit
        assign codes[i]   = encode_bit(tc_in[i], i == SIGN_POS);
        assign pos_out[i] = codes[i][1];
        assign neg_out[i] = codes[i][0];
    end

endmodule

// File: rtl/bsd_conv_rev.sv
module bsd_conv_rev #(
    parameter int K = 16
) (
    input  logic [K-1:0] pos_in,
    input  logic [K-1:0] neg_in,
    output logic [K:0]   tc_out
);

    localparam int OW = K + 1;

    logic [OW-1:0] pos_ext;
    logic [OW-1:0] neg_ext;

    // Both vectors are unsigned magnitudes; one extra bit carries the sign
    assign pos_ext = {1'b0, pos_in};
    assign neg_ext = {1'b0, neg_in};
    assign tc_out  = pos_ext - neg_ext;

endmodule

// File: rtl/bsd_conv_stage.sv
module bsd_conv_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    if (REG) begin : g_reg
        logic         held_v;
        logic [W-1:0] held_d;

        assign in_ready  = !held_v || out_ready;
        assign out_valid = held_v;
        assign out_data  = held_d;

        always_ff @(posedge clk) begin
            if (rst) begin
                held_v <= 1'b0;
            end else if (in_valid && in_ready) begin
                held_v <= 1'b1;
            end else if (out_ready) begin
                held_v <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (in_valid && in_ready)
                held_d <= in_data;
        end
    end else begin : g_comb
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign out_data  = in_data;
    end

endmodule

// File: rtl/bsd_conv.sv
module bsd_conv
    import bsd_conv_pkg::*;
#(
    parameter int K       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tc_valid,
    output logic         tc_ready,
    input  logic [K-1:0] tc_data,
    output logic         fo_valid,
    input  logic         fo_ready,
    output logic [K-1:0] fo_pos,
    output logic [K-1:0] fo_neg,
    input  logic         bd_valid,
    output logic         bd_ready,
    input  logic [K-1:0] bd_pos,
    input  logic [K-1:0] bd_neg,
    output logic         ro_valid,
    input  logic         ro_ready,
    output logic [K:0]   ro_data
);

    localparam int FW = 2 * K;
    localparam int RW = K + 1;

    logic [K-1:0]  f_pos;
    logic [K-1:0]  f_neg;
    logic [RW-1:0] r_val;
    logic [FW-1:0] f_out;

    bsd_conv_fwd #(.K(K)) u_fwd (
        .tc_in  (tc_data),
        .pos_out(f_pos),
        .neg_out(f_neg)
    );

    bsd_conv_rev #(.K(K)) u_rev (
        .pos_in(bd_pos),
        .neg_in(bd_neg),
        .tc_out(r_val)
    );

    bsd_conv_stage #(.W(FW), .REG(REG_OUT)) u_fstage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tc_valid),
        .in_ready (tc_ready),
        .in_data  ({f_pos, f_neg}),
        .out_valid(fo_valid),
        .out_ready(fo_ready),
        .out_data (f_out)
    );

    assign fo_pos = f_out[FW-1:K];
    assign fo_neg = f_out[K-1:0];

    bsd_conv_stage #(.W(RW), .REG(REG_OUT)) u_rstage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (bd_valid),
        .in_ready (bd_ready),
        .in_data  (r_val),
        .out_valid(ro_valid),
        .out_ready(ro_ready),
        .out_data (ro_data)
    );

endmodule

// File: rtl/bsd_conv_chk.sv
module bsd_conv_chk #(
    parameter int K       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         fo_valid,
    input logic         fo_ready,
    input logic [K-1:0] fo_pos,
    input logic [K-1:0] fo_neg,
    input logic         ro_valid,
    input logic         ro_ready,
    input logic [K:0]   ro_data
);

    localparam logic [K:0] MOST_NEG = {1'b1, {K{1'b0}}};

    // R4
    fwd_no_both_chk: assert property (@(posedge clk) disable iff (rst)
        fo_valid |-> ((fo_pos & fo_neg) == '0));

    // R2
    fwd_sign_only_chk: assert property (@(posedge clk) disable iff (rst)
        fo_valid |-> (!fo_pos[K-1] && (fo_neg[K-2:0] == '0)));

    // R7
    rev_range_chk: assert property (@(posedge clk) disable iff (rst)
        ro_valid |-> (ro_data != MOST_NEG));

    // R8
    fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (REG_OUT && fo_valid && !fo_ready) |=>
            (fo_valid && $stable(fo_pos) && $stable(fo_neg)));

    // R8
    rev_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (REG_OUT && ro_valid && !ro_ready) |=> (ro_valid && $stable(ro_data)));

    // R10
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (REG_OUT && $past(rst)) |-> (!fo_valid && !ro_valid));

endmodule

bind bsd_conv bsd_conv_chk #(.K(K), .REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fo_valid(fo_valid),
    .fo_ready(fo_ready),
    .fo_pos  (fo_pos),
    .fo_neg  (fo_neg),
    .ro_valid(ro_valid),
    .ro_ready(ro_ready),
    .ro_data (ro_data)
);

// File: tb/tb_bsd_conv.sv
module tb_bsd_conv;

    localparam int K = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         tc_valid = 1'b0, fo_ready = 1'b0, bd_valid = 1'b0, ro_ready = 1'b0;
    logic [K-1:0] tc_data = '0, bd_pos = '0, bd_neg = '0;
    logic         tc_ready, fo_valid, bd_ready, ro_valid;
    logic [K-1:0] fo_pos, fo_neg;
    logic [K:0]   ro_data;
    logic         c_tc_ready, c_fo_valid, c_bd_ready, c_ro_valid;
    logic [K-1:0] c_fo_pos, c_fo_neg;
    logic [K:0]   c_ro_data;

    bsd_conv #(.K(K), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst),
        .tc_valid(tc_valid), .tc_ready(tc_ready), .tc_data(tc_data),
        .fo_valid(fo_valid), .fo_ready(fo_ready), .fo_pos(fo_pos), .fo_neg(fo_neg),
        .bd_valid(bd_valid), .bd_ready(bd_ready), .bd_pos(bd_pos), .bd_neg(bd_neg),
        .ro_valid(ro_valid), .ro_ready(ro_ready), .ro_data(ro_data)
    );

    bsd_conv #(.K(K), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst(rst),
        .tc_valid(tc_valid), .tc_ready(c_tc_ready), .tc_data(tc_data),
        .fo_valid(c_fo_valid), .fo_ready(fo_ready), .fo_pos(c_fo_pos), .fo_neg(c_fo_neg),
        .bd_valid(bd_valid), .bd_ready(c_bd_ready), .bd_pos(bd_pos), .bd_neg(bd_neg),
        .ro_valid(c_ro_valid), .ro_ready(ro_ready), .ro_data(c_ro_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic [2*K-1:0] fq[$];
    int             rq[$];
    logic [2*K-1:0] cur_f;
    int             cur_r;

    // Expected digit vectors built from R2/R3 directly
    function automatic logic [2*K-1:0] model_fwd(input logic [K-1:0] x);
        logic [K-1:0] p, n;
        p = x;
        p[K-1] = 1'b0;
        n = '0;
        n[K-1] = x[K-1];
        return {p, n};
    endfunction

    function automatic int model_val(input logic [K-1:0] p, input logic [K-1:0] n);
        int v = 0;
        for (int i = 0; i < K; i++) v += (int'(p[i]) - int'(n[i])) * (1 << i);
        return v;
    endfunction

    task automatic send_fwd(input logic [K-1:0] x);
        @(negedge clk);
        tc_valid = 1'b1;
        tc_data  = x;
        cur_f    = model_fwd(x);
        #2;
        while (!tc_ready) begin
            @(negedge clk);
            #2;
        end
        fq.push_back(cur_f);
        @(posedge clk);
        #1 tc_valid = 1'b0;
    endtask

    task automatic send_rev(input logic [K-1:0] p, input logic [K-1:0] n, input int e);
        @(negedge clk);
        bd_valid = 1'b1;
        bd_pos   = p;
        bd_neg   = n;
        cur_r    = e;
        #2;
        while (!bd_ready) begin
            @(negedge clk);
            #2;
        end
        rq.push_back(e);
        @(posedge clk);
        #1 bd_valid = 1'b0;
    endtask

    // Random backpressure
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                fo_ready = ($urandom % 4) != 0;
                ro_ready = ($urandom % 3) != 0;
            end
        end
    end

    // Monitor / scoreboard
    logic           pf_stall = 1'b0, pr_stall = 1'b0;
    logic [2*K-1:0] pf_data;
    logic [K:0]     pr_data;
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                // R8 hold under stall
                if (pf_stall)
                    check(fo_valid && {fo_pos, fo_neg} == pf_data, "R8", int'({fo_pos, fo_neg}), int'(pf_data));
                if (pr_stall)
                    check(ro_valid && ro_data == pr_data, "R8", int'(ro_data), int'(pr_data));
                pf_stall = fo_valid && !fo_ready;
                pr_stall = ro_valid && !ro_ready;
                pf_data  = {fo_pos, fo_neg};
                pr_data  = ro_data;
                check(tc_ready == (!fo_valid || fo_ready), "R8", int'(tc_ready), int'(!fo_valid || fo_ready));
                // R9 combinational instance
                check(c_tc_ready == fo_ready && c_fo_valid == tc_valid && c_bd_ready == ro_ready && c_ro_valid == bd_valid,
                      "R9", int'({c_tc_ready, c_fo_valid, c_bd_ready, c_ro_valid}),
                      int'({fo_ready, tc_valid, ro_ready, bd_valid}));
                if (tc_valid)
                    check({c_fo_pos, c_fo_neg} == cur_f, "R9", int'({c_fo_pos, c_fo_neg}), int'(cur_f));
                if (bd_valid)
                    check(int'($signed(c_ro_data)) == cur_r, "R9", int'($signed(c_ro_data)), cur_r);
                if (fo_valid && fo_ready) begin
                    if (fq.size() == 0) check(1'b0, "R8", 1, 0);
                    else begin
                        logic [2*K-1:0] e;
                        e = fq.pop_front();
                        check(fo_pos == e[2*K-1:K], "R3", int'(fo_pos), int'(e[2*K-1:K]));
                        check(fo_neg == e[K-1:0], "R2", int'(fo_neg), int'(e[K-1:0]));
                        check((fo_pos & fo_neg) == '0, "R4", int'(fo_pos & fo_neg), 0);
                    end
                end
                if (ro_valid && ro_ready) begin
                    if (rq.size() == 0) check(1'b0, "R8", 1, 0);
                    else begin
                        int e;
                        e = rq.pop_front();
                        check(int'($signed(ro_data)) == e, "R5", int'($signed(ro_data)), e);
                    end
                end
            end
        end
    end

    bit finished = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!fo_valid && !ro_valid, "R10", int'({fo_valid, ro_valid}), 0);
        check(tc_ready && bd_ready, "R10", int'({tc_ready, bd_ready}), 3);

        fork
            begin
                // R1 R2 R3 R4: exhaustive forward
                for (int x = 0; x < (1 << K); x++) send_fwd(K'(x));
            end
            begin
                // R11 round trip: every input, through the encoding, back out
                for (int x = 0; x < (1 << K); x++) begin
                    logic [2*K-1:0] f;
                    logic [K-1:0] xv;
                    xv = K'(x);
                    f  = model_fwd(xv);
                    send_rev(f[2*K-1:K], f[K-1:0], int'($signed(xv)));
                end
                // R7 extremes
                send_rev('1, '0, (1 << K) - 1);
                send_rev('0, '1, -((1 << K) - 1));
                // R6 redundant forms of +5 and a digit with both bits set
                send_rev(6'b000101, 6'b000000, 5);
                send_rev(6'b000111, 6'b000010, 5);
                send_rev(6'b001011, 6'b000110, 5);
                send_rev(6'b111111, 6'b111111, 0);
                send_rev(6'b100101, 6'b100000, 5);
                // R5 random pairs
                for (int i = 0; i < 400; i++) begin
                    logic [K-1:0] p, n;
                    p = K'($urandom);
                    n = K'($urandom);
                    send_rev(p, n, model_val(p, n));
                end
            end
        join
        while (fq.size() != 0 || rq.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule